// File: doc/BRIEF.md
# Management-Mode and Stop-Clock Sequencer

This block decides when a processor core enters and leaves its system management mode, and how it answers a stop-clock request. Two inputs are asynchronous: a management interrupt, which triggers on a falling edge, and an active-low stop request, which is a level. Each one passes through a synchronizer. The core sends a strobe at every instruction boundary. Both kinds of event take effect only at such a boundary, and only while the block is in its run state.

A recognised management interrupt raises a one-cycle take pulse to the core and drives the active-low management flag low. The flag stays low through the save phase, the body of the handler and the restore phase. It goes high once the core reports that the last restore cycle has finished. A falling edge that arrives while management mode is active is held as a single pending event. It is taken at the first instruction boundary after the mode has been left.

A stop request first halts the core. The sequencer then waits for the write buffers to report that they are empty. Next it issues a one-cycle special bus cycle request that carries the stop-grant code. The core stays halted until the request is withdrawn.

Top module: `mgmt_clk_ctrl`

## Requirements
- R1: A falling edge on `mgmt_irq_n` is recognised after the synchronizer. It is taken only at an `insn_bnd` strobe while the block is in run state. In the cycle after that strobe, `take_mgmt` is high, and it stays high for exactly one cycle.
- R2: While management mode is active (`mgmt_active_n` low), an `insn_bnd` strobe never produces `take_mgmt`.
- R3: Any number of falling edges during management mode collapse into one pending event. That event is taken at the first boundary after the return to run state, and no second take follows it.
- R4: `mgmt_active_n` goes low in the same cycle as the `take_mgmt` pulse. It stays low across `resume_done` and goes high in the cycle after `restore_done`.
- R5: A stop request (`stop_req_n` low, after the synchronizer) seen at a boundary in run state sets `core_halt` high from the next cycle on. `core_halt` then stays high through drain, special cycle and grant.
- R6: Once `wbuf_empty` is high during drain, `spc_req` is high for exactly one cycle with `spc_be_n` = 4'b1011 and `spc_addr` = 3'b100. At all other times `spc_be_n` is 4'b1111 and `spc_addr` is 3'b000.
- R7: After the special cycle, `core_halt` stays high while the stop request is held. Once the synchronized request is released, the block returns to run state on the next clock and `core_halt` drops.
- R8: If a management event is pending and a stop request is active at the same boundary, the management event is taken and the stop request waits.
- R9: A falling edge that arrives during the stop sequence stays pending. It is taken at the first boundary after the stop request is released.
- R10: Under reset, `mgmt_active_n` is 1 and `take_mgmt`, `spc_req` and `core_halt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_irq_n | input | 1 | Asynchronous management interrupt, falling-edge triggered |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| insn_bnd | input | 1 | Instruction-boundary strobe from the core |
| resume_done | input | 1 | Strobe: the resume instruction has completed |
| restore_done | input | 1 | Strobe: the last state-restore cycle has finished |
| wbuf_empty | input | 1 | The write buffers have drained |
| mgmt_active_n | output | 1 | Active-low management-mode flag |
| take_mgmt | output | 1 | One-cycle pulse telling the core to enter management mode |
| spc_req | output | 1 | One-cycle special bus cycle request |
| spc_be_n | output | 4 | Active-low byte-enable code of the special cycle |
| spc_addr | output | 3 | Address code (bits 4..2) of the special cycle |
| core_halt | output | 1 | Holds the core stopped during the stop sequence |

## Verification
The assertions rely on the core sending `resume_done` only inside management mode and `restore_done` only after it. They also rely on the stop request staying low until the grant cycle has gone out. The random stimulus enforces these rules with a bench model of the controller phase. It drives the two completion strobes only in their matching phase. It releases the stop request only once the model has reached the granted state, and it asserts the request only from run state. The interrupt line and the boundary and drain strobes are left free, so edges land in every phase.

// File: rtl/mscc_pkg.sv
package mscc_pkg;
   localparam int BE_W   = 4;
   localparam int CODE_W = 3;

   typedef enum logic [2:0] {
      ST_RUN, ST_MGMT, ST_RESTORE, ST_DRAIN, ST_SPECIAL, ST_GRANTED
   } ctl_state_t;

   typedef enum logic [1:0] {SPC_SHUTDOWN, SPC_HALT, SPC_STOPGRANT} spc_kind_t;

   typedef struct packed {
      logic [BE_W-1:0]   be_n;
      logic [CODE_W-1:0] addr;
   } spc_code_t;

   localparam spc_code_t SPC_IDLE = '{be_n: 4'b1111, addr: 3'b000};

   function automatic spc_code_t spc_encode(spc_kind_t kind);
      spc_code_t c;
      case (kind)
         SPC_SHUTDOWN:  c = '{be_n: 4'b1110, addr: 3'b000};
         SPC_HALT:      c = '{be_n: 4'b1011, addr: 3'b000};
         SPC_STOPGRANT: c = '{be_n: 4'b1011, addr: 3'b100};
         default:       c = SPC_IDLE;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/mscc_sync.sv
module mscc_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mscc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/mscc_pend.sv
module mscc_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_sync_n,
   input  logic take,
   output logic pend
);
   logic prev_n;
   logic fall;

   assign fall = prev_n & ~irq_sync_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n <= 1'b1;
         pend   <= 1'b0;
      end else begin
         prev_n <= irq_sync_n;
         // a new edge wins over the clear of the one being taken
         pend   <= fall | (pend & ~take);
      end
   end
endmodule

// File: rtl/mscc_seq.sv
module mscc_seq
   import mscc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pend,
   input  logic      stop_act,
   input  logic      insn_bnd,
   input  logic      resume_done,
   input  logic      restore_done,
   input  logic      wbuf_empty,
   output logic      take_now,
   output logic      take_mgmt,
   output logic      mgmt_active_n,
   output logic      spc_req,
   output spc_code_t spc_code,
   output logic      core_halt
);
   ctl_state_t state, state_nxt;

   assign take_now = (state == ST_RUN) && insn_bnd && pend;

   always_comb begin
      state_nxt = state;
      case (state)
         ST_RUN: begin
            if (take_now)                  state_nxt = ST_MGMT;
            else if (insn_bnd && stop_act) state_nxt = ST_DRAIN;
         end
         ST_MGMT:    if (resume_done)  state_nxt = ST_RESTORE;
         ST_RESTORE: if (restore_done) state_nxt = ST_RUN;
         ST_DRAIN:   if (wbuf_empty)   state_nxt = ST_SPECIAL;
         ST_SPECIAL:                   state_nxt = ST_GRANTED;
         ST_GRANTED: if (!stop_act)    state_nxt = ST_RUN;
         default:                      state_nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         take_mgmt <= 1'b0;
      end else begin
         state     <= state_nxt;
         take_mgmt <= take_now;
      end
   end

   assign mgmt_active_n = !((state == ST_MGMT) || (state == ST_RESTORE));
   assign spc_req       = (state == ST_SPECIAL);
   assign spc_code      = spc_req ? spc_encode(SPC_STOPGRANT) : SPC_IDLE;
   assign core_halt     = (state == ST_DRAIN) || (state == ST_SPECIAL) ||
                          (state == ST_GRANTED);
endmodule

// File: rtl/mgmt_clk_ctrl.sv
module mgmt_clk_ctrl
   import mscc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mgmt_irq_n,
   input  logic              stop_req_n,
   input  logic              insn_bnd,
   input  logic              resume_done,
   input  logic              restore_done,
   input  logic              wbuf_empty,
   output logic              mgmt_active_n,
   output logic              take_mgmt,
   output logic              spc_req,
   output logic [BE_W-1:0]   spc_be_n,
   output logic [CODE_W-1:0] spc_addr,
   output logic              core_halt
);
   localparam int N_ASYNC = 2;

   logic [N_ASYNC-1:0] async_sync;
   logic               pend;
   logic               take_now;
   spc_code_t          code;

   mscc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({stop_req_n, mgmt_irq_n}),
      .dout (async_sync)
   );

   mscc_pend pend_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_sync_n(async_sync[0]),
      .take      (take_now),
      .pend      (pend)
   );

   mscc_seq seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend         (pend),
      .stop_act     (~async_sync[1]),
      .insn_bnd     (insn_bnd),
      .resume_done  (resume_done),
      .restore_done (restore_done),
      .wbuf_empty   (wbuf_empty),
      .take_now     (take_now),
      .take_mgmt    (take_mgmt),
      .mgmt_active_n(mgmt_active_n),
      .spc_req      (spc_req),
      .spc_code     (code),
      .core_halt    (core_halt)
   );

   assign spc_be_n = code.be_n;
   assign spc_addr = code.addr;
endmodule

// File: rtl/mgmt_clk_ctrl_chk.sv
module mgmt_clk_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       take_mgmt,
   input logic       mgmt_active_n,
   input logic       spc_req,
   input logic [3:0] spc_be_n,
   input logic [2:0] spc_addr,
   input logic       core_halt
);
   AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      take_mgmt |=> !take_mgmt); // R1
   AST_NO_TAKE_IN_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
      (!mgmt_active_n && !take_mgmt) |=> !take_mgmt); // R2
   AST_TAKE_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      take_mgmt |-> !mgmt_active_n); // R4
   AST_HALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_halt && !mgmt_active_n)); // R5
   AST_SPC_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |-> core_halt); // R5
   AST_SPC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |-> (spc_be_n == 4'b1011 && spc_addr == 3'b100)); // R6
   AST_SPC_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !spc_req |-> (spc_be_n == 4'b1111 && spc_addr == 3'b000)); // R6
   AST_SPC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |=> !spc_req); // R6
   AST_SPC_THEN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |=> core_halt); // R7
endmodule

bind mgmt_clk_ctrl mgmt_clk_ctrl_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .take_mgmt    (take_mgmt),
   .mgmt_active_n(mgmt_active_n),
   .spc_req      (spc_req),
   .spc_be_n     (spc_be_n),
   .spc_addr     (spc_addr),
   .core_halt    (core_halt)
);

// File: tb/mgmt_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module mgmt_clk_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mgmt_irq_n = 1'b1, stop_req_n = 1'b1;
   logic       insn_bnd = 1'b0, resume_done = 1'b0, restore_done = 1'b0;
   logic       wbuf_empty = 1'b0;
   logic       mgmt_active_n, take_mgmt, spc_req, core_halt;
   logic [3:0] spc_be_n;
   logic [2:0] spc_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mgmt_clk_ctrl dut_i (.*);

   // bench model of the controller, built from the requirements
   localparam int M_RUN = 0, M_MGMT = 1, M_REST = 2, M_DRAIN = 3, M_SPC = 4, M_GRANT = 5;
   int mst;
   bit ms1, ms2, mprev, ss1, ss2, mpend, mtake;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst = M_RUN; ms1 = 1; ms2 = 1; mprev = 1; ss1 = 1; ss2 = 1;
         mpend = 0; mtake = 0;
      end else begin
         bit fall, stopv, tk;
         int nst;
         fall  = mprev & ~ms2;
         stopv = ~ss2;
         tk    = (mst == M_RUN) && insn_bnd && mpend;
         nst   = mst;
         case (mst)
            M_RUN:   if (tk) nst = M_MGMT; else if (insn_bnd && stopv) nst = M_DRAIN;
            M_MGMT:  if (resume_done) nst = M_REST;
            M_REST:  if (restore_done) nst = M_RUN;
            M_DRAIN: if (wbuf_empty) nst = M_SPC;
            M_SPC:   nst = M_GRANT;
            M_GRANT: if (!stopv) nst = M_RUN;
            default: nst = M_RUN;
         endcase
         mprev = ms2; ms2 = ms1; ms1 = mgmt_irq_n;
         ss2 = ss1; ss1 = stop_req_n;
         mpend = fall | (mpend & ~tk);
         mtake = tk;
         mst = nst;
      end
   end

   function automatic bit exp_active_n(int s); return !(s == M_MGMT || s == M_REST); endfunction
   function automatic bit exp_halt(int s); return s == M_DRAIN || s == M_SPC || s == M_GRANT; endfunction
   function automatic logic [6:0] exp_code(int s);
      return (s == M_SPC) ? {4'b1011, 3'b100} : {4'b1111, 3'b000};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // every cycle: outputs against the model
   always @(negedge clk) if (rst_n && !done) begin
      chk(take_mgmt == mtake, "R1 take_mgmt", 7'(take_mgmt), 7'(mtake));
      chk(mgmt_active_n == exp_active_n(mst), "R4 mgmt_active_n", 7'(mgmt_active_n), 7'(exp_active_n(mst)));
      chk(core_halt == exp_halt(mst), "R5 core_halt", 7'(core_halt), 7'(exp_halt(mst)));
      chk(spc_req == (mst == M_SPC), "R6 spc_req", 7'(spc_req), 7'(mst == M_SPC));
      chk({spc_be_n, spc_addr} == exp_code(mst), "R6 spc code", {spc_be_n, spc_addr}, exp_code(mst));
   end

   task automatic step(input int n); repeat (n) @(negedge clk); endtask
   task automatic pulse_bnd;     insn_bnd = 1;     step(1); insn_bnd = 0;     endtask
   task automatic pulse_resume;  resume_done = 1;  step(1); resume_done = 0;  endtask
   task automatic pulse_restore; restore_done = 1; step(1); restore_done = 0; endtask

   task automatic finish_run;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20250611));
      step(3);
      // R10: reset state
      chk(mgmt_active_n === 1'b1 && take_mgmt === 1'b0 && spc_req === 1'b0 && core_halt === 1'b0,
          "R10 reset state", {3'b0, mgmt_active_n, take_mgmt, spc_req, core_halt}, 7'b0001000);
      rst_n = 1'b1;
      step(2);

      // R8: pending event and stop request meet at one boundary
      mgmt_irq_n = 0; stop_req_n = 0; step(5); mgmt_irq_n = 1;
      pulse_bnd();
      chk(take_mgmt && !core_halt, "R8 priority", {5'b0, take_mgmt, core_halt}, 7'b10);
      chk(!mgmt_active_n, "R4 active with take", 7'(mgmt_active_n), 7'd0);
      step(1);
      chk(!take_mgmt, "R1 single pulse", 7'(take_mgmt), 7'd0);

      // R2: no entry while active; R3: two edges collapse
      pulse_bnd();
      chk(!take_mgmt, "R2 no nested take", 7'(take_mgmt), 7'd0);
      step(2); mgmt_irq_n = 0; step(3); mgmt_irq_n = 1; step(3);
      mgmt_irq_n = 0; step(3); mgmt_irq_n = 1; step(3);
      pulse_resume();
      chk(!mgmt_active_n, "R4 held across resume", 7'(mgmt_active_n), 7'd0);
      pulse_restore();
      chk(mgmt_active_n, "R4 released after restore", 7'(mgmt_active_n), 7'd1);
      pulse_bnd();
      chk(take_mgmt, "R3 pending taken", 7'(take_mgmt), 7'd1);
      step(1); pulse_resume(); pulse_restore();
      pulse_bnd();
      chk(!take_mgmt && core_halt, "R3 collapsed / R5 halt", {5'b0, take_mgmt, core_halt}, 7'b01);

      // R6 / R7: drain, special cycle, grant
      step(2);
      chk(core_halt && !spc_req, "R5 drain waits", {5'b0, core_halt, spc_req}, 7'b10);
      wbuf_empty = 1; step(1); wbuf_empty = 0;
      chk(spc_req && {spc_be_n, spc_addr} == 7'b1011100, "R6 stop-grant code",
          {spc_be_n, spc_addr}, 7'b1011100);
      step(1);
      chk(!spc_req && core_halt, "R7 granted", {5'b0, spc_req, core_halt}, 7'b01);

      // R9: edge during grant preserved
      mgmt_irq_n = 0; step(3); mgmt_irq_n = 1; step(3);
      chk(core_halt && !take_mgmt, "R9 held in grant", {5'b0, core_halt, take_mgmt}, 7'b10);
      stop_req_n = 1; step(4);
      chk(!core_halt, "R7 release", 7'(core_halt), 7'd0);
      pulse_bnd();
      chk(take_mgmt, "R9 taken after release", 7'(take_mgmt), 7'd1);
      step(1); pulse_resume(); pulse_restore(); step(2);

      // constrained random phase
      for (int cyc = 0; cyc < 4000; cyc++) begin
         insn_bnd     = ($urandom % 4) == 0;
         resume_done  = (mst == M_MGMT) && (($urandom % 6) == 0);
         restore_done = (mst == M_REST) && (($urandom % 4) == 0);
         wbuf_empty   = ($urandom % 3) == 0;
         if (($urandom % 5) == 0) mgmt_irq_n = ~mgmt_irq_n;
         if (stop_req_n && mst == M_RUN && ($urandom % 10) == 0) stop_req_n = 0;
         else if (!stop_req_n && mst == M_GRANT && ($urandom % 4) == 0) stop_req_n = 1;
         step(1);
      end
      finish_run();
   end
endmodule